// File: doc/BRIEF.md
# ASID-aware associative TLB lookup

This block keeps a small fully associative unified translation table together with a four-entry companion instruction table. A lookup presents a virtual page number together with the current address-space identifier. The block reports in the same cycle whether a valid unified entry matches. On a hit it also reports the lowest matching slot and that slot's dirty flag.

Each entry carries a shared flag that makes it match under any address-space identifier. Identifier comparison is switched off entirely when the processor is privileged and the single-virtual-space control is set. Software fills entries with a load command. For a unified entry, the slot is the one named by a replacement pointer; that pointer moves only on lookups that hit. For an instruction entry, the slot is named in the command.

Software can also issue an associative write. It carries a page number and a 10-bit data word that holds new dirty and valid flags and an identifier. The write finds the matching unified entry and rewrites its flags. If several unified entries match, the write raises a multiple-hit exception code instead of changing anything. The same write also searches the instruction table. Any instruction entry that matches takes the new valid flag. If such an entry loses its valid flag, the block requests a flush.

Top module: `pgtlb_top`

## Requirements
- R1: After reset no entry is valid, the replacement pointer is 0, `exc_code` is 0 and `flush_req` is 0.
- R2: A lookup hits only on a unified entry whose valid flag is set and whose page number equals `lkp_vpn`, and (while identifiers are checked) whose stored identifier equals `cur_asid`.
- R3: A unified entry with its shared flag set matches regardless of its stored identifier.
- R4: Identifier checking is off only when `priv_mode` = 1 and `single_vmode` = 1; with either at 0 the identifiers must be equal (or the entry shared). The same rule governs lookups and associative writes.
- R5: `hit`, `hit_idx` and `hit_dirty` are combinational. `hit_idx` is the lowest matching slot and `hit_dirty` is that slot's dirty flag. All three are 0 when `lkp_req` is 0 or nothing matches.
- R6: With `load_req` = 1 and `load_to_itlb` = 0, the unified slot at the replacement pointer takes the load fields on the next edge. With `load_to_itlb` = 1, the instruction slot `load_islot` takes them instead. A load never moves the pointer.
- R7: The replacement pointer advances by one at the edge that ends each cycle with `hit` = 1, and wraps from 63 to 0.
- R8: An associative write uses `aw_data[9]` as the new dirty flag, `aw_data[8]` as the new valid flag and `aw_data[7:0]` as the identifier. When exactly one valid unified entry matches `aw_vpn`, that entry takes both new flags on the next edge. With no match, the unified table is left unchanged.
- R9: When two or more valid unified entries match an associative write, `exc_code` shows 0x140 for the following cycle and no unified entry changes; otherwise `exc_code` is 0.
- R10: An associative write matches instruction entries by page number and identifier rule, whatever their valid flag. Each matching instruction entry takes the new valid flag. `flush_req` pulses for the following cycle when a matching instruction entry was valid and the new valid flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkp_req | input | 1 | Lookup request |
| lkp_vpn | input | 22 | Lookup virtual page number |
| cur_asid | input | 8 | Current address-space identifier |
| priv_mode | input | 1 | 1 = privileged mode |
| single_vmode | input | 1 | Single-virtual-space control |
| load_req | input | 1 | Load-entry command |
| load_to_itlb | input | 1 | 1 = load targets the instruction table |
| load_islot | input | 2 | Instruction slot for a load |
| load_vpn | input | 22 | Page number to load |
| load_asid | input | 8 | Identifier to load |
| load_shared | input | 1 | Shared flag to load |
| load_valid | input | 1 | Valid flag to load |
| load_dirty | input | 1 | Dirty flag to load |
| aw_req | input | 1 | Associative write request |
| aw_vpn | input | 22 | Page number for the associative write |
| aw_data | input | 10 | Dirty [9], valid [8], identifier [7:0] |
| hit | output | 1 | Lookup hit |
| hit_idx | output | 6 | Lowest matching unified slot |
| hit_dirty | output | 1 | Dirty flag of the hit slot |
| exc_code | output | 12 | 0x140 after a multiple match on associative write, else 0 |
| flush_req | output | 1 | One-cycle flush request |

## Verification
The multiple-match exception is the hardest case to reach. In normal use the pointer rotates, so two valid unified entries with the same page number only exist if software places them there on purpose. The stimulus therefore loads one page under identifier 2, then makes a hit to move the pointer, then loads the same page under identifier 3. It then issues an associative write in privileged single-virtual mode, so identifiers are ignored and both entries match. The wrap of the replacement pointer is reached by repeating hitting lookups more than 64 times before the next load, and the slot that load writes is then revealed through `hit_idx`.

// File: rtl/pgtlb_pkg.sv
package pgtlb_pkg;

    localparam int VPN_W   = 22;
    localparam int ASID_W  = 8;
    localparam int EXC_W   = 12;
    localparam int AW_W    = 10;
    localparam int AW_DIRTY_BIT = 9;
    localparam int AW_VALID_BIT = 8;
    localparam logic [EXC_W-1:0] EXC_MULTI_HIT = 12'h140;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic              shared;
        logic              valid;
        logic              dirty;
    } tlb_entry_t;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic              chk_asid;
        logic              need_valid;
    } tlb_probe_t;

    // identifiers are ignored only in privileged single-virtual mode
    function automatic logic asid_checking(input logic priv, input logic svm);
        return !(priv && svm);
    endfunction

    function automatic logic entry_hits(input tlb_entry_t e, input tlb_probe_t p);
        return (e.valid || !p.need_valid) && (e.vpn == p.vpn) &&
               (!p.chk_asid || e.shared || (e.asid == p.asid));
    endfunction

endpackage

// File: rtl/pgtlb_match.sv
module pgtlb_match import pgtlb_pkg::*; #(
    parameter int N = 4
) (
    input  tlb_entry_t ents [N],
    input  tlb_probe_t probe,
    output logic [N-1:0] mvec
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign mvec[g] = entry_hits(ents[g], probe);
    end
endmodule

// File: rtl/pgtlb_prio.sv
module pgtlb_prio #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic          multi
);
    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

    assign any   = |vec;
    assign multi = |(vec & (vec - ONE));
endmodule

// File: rtl/pgtlb_repl.sv
module pgtlb_repl #(
    parameter int N  = 64,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [IW-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (adv)
            ptr <= (ptr == IW'(N - 1)) ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/pgtlb_top.sv
module pgtlb_top import pgtlb_pkg::*; #(
    parameter int U_ENTRIES = 64,
    parameter int I_ENTRIES = 4,
    localparam int UIW = $clog2(U_ENTRIES),
    localparam int IIW = $clog2(I_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lkp_req,
    input  logic [VPN_W-1:0]  lkp_vpn,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              priv_mode,
    input  logic              single_vmode,
    input  logic              load_req,
    input  logic              load_to_itlb,
    input  logic [IIW-1:0]    load_islot,
    input  logic [VPN_W-1:0]  load_vpn,
    input  logic [ASID_W-1:0] load_asid,
    input  logic              load_shared,
    input  logic              load_valid,
    input  logic              load_dirty,
    input  logic              aw_req,
    input  logic [VPN_W-1:0]  aw_vpn,
    input  logic [AW_W-1:0]   aw_data,
    output logic              hit,
    output logic [UIW-1:0]    hit_idx,
    output logic              hit_dirty,
    output logic [EXC_W-1:0]  exc_code,
    output logic              flush_req
);
    tlb_entry_t utlb [U_ENTRIES];
    tlb_entry_t itlb [I_ENTRIES];

    tlb_probe_t lk_probe, aw_u_probe, aw_i_probe;
    tlb_entry_t new_ent;
    logic       chk_asid, aw_dirty, aw_valid;

    always_comb begin
        chk_asid = asid_checking(priv_mode, single_vmode);
        aw_dirty = aw_data[AW_DIRTY_BIT];
        aw_valid = aw_data[AW_VALID_BIT];
        lk_probe   = '{vpn: lkp_vpn, asid: cur_asid, chk_asid: chk_asid, need_valid: 1'b1};
        aw_u_probe = '{vpn: aw_vpn, asid: aw_data[ASID_W-1:0], chk_asid: chk_asid, need_valid: 1'b1};
        aw_i_probe = '{vpn: aw_vpn, asid: aw_data[ASID_W-1:0], chk_asid: chk_asid, need_valid: 1'b0};
        new_ent    = '{vpn: load_vpn, asid: load_asid, shared: load_shared,
                       valid: load_valid, dirty: load_dirty};
    end

    // ---------------- match vectors ----------------
    logic [U_ENTRIES-1:0] lk_mvec, aw_u_mvec;
    logic [I_ENTRIES-1:0] aw_i_mvec, i_valid_vec;

    pgtlb_match #(.N(U_ENTRIES)) lk_match_i   (.ents(utlb), .probe(lk_probe),   .mvec(lk_mvec));
    pgtlb_match #(.N(U_ENTRIES)) aw_u_match_i (.ents(utlb), .probe(aw_u_probe), .mvec(aw_u_mvec));
    pgtlb_match #(.N(I_ENTRIES)) aw_i_match_i (.ents(itlb), .probe(aw_i_probe), .mvec(aw_i_mvec));

    for (genvar g = 0; g < I_ENTRIES; g++) begin : g_ival
        assign i_valid_vec[g] = itlb[g].valid;
    end

    // ---------------- encoders ----------------
    logic           lk_any, lk_multi, aw_u_any, aw_u_multi;
    logic [UIW-1:0] lk_idx, aw_u_idx;

    pgtlb_prio #(.N(U_ENTRIES)) lk_prio_i (
        .vec(lk_mvec), .any(lk_any), .idx(lk_idx), .multi(lk_multi));
    pgtlb_prio #(.N(U_ENTRIES)) aw_prio_i (
        .vec(aw_u_mvec), .any(aw_u_any), .idx(aw_u_idx), .multi(aw_u_multi));

    // lookup output; several matches simply report the lowest slot
    logic lk_multi_unused;
    assign lk_multi_unused = lk_multi;
    assign hit       = lkp_req && lk_any;
    assign hit_idx   = hit ? lk_idx : '0;
    assign hit_dirty = hit && utlb[lk_idx].dirty;

    // ---------------- replacement pointer ----------------
    logic [UIW-1:0] repl_ptr;

    pgtlb_repl #(.N(U_ENTRIES)) repl_i (.clk(clk), .rst(rst), .adv(hit), .ptr(repl_ptr));

    // ---------------- storage and write ports ----------------
    logic aw_single;
    assign aw_single = aw_req && aw_u_any && !aw_u_multi;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < U_ENTRIES; i++) utlb[i] <= '0;
            for (int i = 0; i < I_ENTRIES; i++) itlb[i] <= '0;
            exc_code  <= '0;
            flush_req <= 1'b0;
        end else begin
            if (aw_single) begin
                utlb[aw_u_idx].dirty <= aw_dirty;
                utlb[aw_u_idx].valid <= aw_valid;
            end
            if (aw_req) begin
                for (int i = 0; i < I_ENTRIES; i++)
                    if (aw_i_mvec[i]) itlb[i].valid <= aw_valid;
            end
            // a load is applied last and overrides a write to the same slot
            if (load_req) begin
                if (load_to_itlb) itlb[load_islot] <= new_ent;
                else              utlb[repl_ptr]   <= new_ent;
            end
            exc_code  <= (aw_req && aw_u_multi) ? EXC_MULTI_HIT : '0;
            flush_req <= aw_req && !aw_valid && |(aw_i_mvec & i_valid_vec);
        end
    end
endmodule

// File: rtl/pgtlb_chk.sv
module pgtlb_chk import pgtlb_pkg::*; #(
    parameter int U_ENTRIES = 64,
    localparam int UIW = $clog2(U_ENTRIES)
) (
    input logic             clk,
    input logic             rst,
    input logic             lkp_req,
    input logic             hit,
    input logic [UIW-1:0]   hit_idx,
    input logic             aw_req,
    input logic [AW_W-1:0]  aw_data,
    input logic [EXC_W-1:0] exc_code,
    input logic             flush_req,
    input logic [UIW-1:0]   repl_ptr
);
    // R5
    hit_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !lkp_req |-> (!hit && hit_idx == '0));

    // R9
    exc_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_code == '0) || (exc_code == EXC_MULTI_HIT));

    // R9
    exc_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_code != '0) |-> $past(aw_req));

    // R10
    flush_cause_chk: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> ($past(aw_req) && !$past(aw_data[AW_VALID_BIT])));

    // R7
    repl_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(hit)) |->
        (repl_ptr == (($past(repl_ptr) == UIW'(U_ENTRIES - 1)) ? '0 : $past(repl_ptr) + 1'b1)));

    // R6
    repl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(hit)) |-> $stable(repl_ptr));
endmodule

bind pgtlb_top pgtlb_chk #(.U_ENTRIES(U_ENTRIES)) chk_i (
    .clk(clk), .rst(rst), .lkp_req(lkp_req), .hit(hit), .hit_idx(hit_idx),
    .aw_req(aw_req), .aw_data(aw_data), .exc_code(exc_code),
    .flush_req(flush_req), .repl_ptr(repl_ptr));

// File: tb/pgtlb_top_tb_top.sv
`timescale 1ns/1ps
module pgtlb_top_tb_top;
    localparam int NU = 64;
    localparam int NI = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lkp_req = 0, priv_mode = 0, single_vmode = 0;
    logic [21:0] lkp_vpn = '0;
    logic [7:0]  cur_asid = '0;
    logic        load_req = 0, load_to_itlb = 0, load_shared = 0, load_valid = 0, load_dirty = 0;
    logic [1:0]  load_islot = '0;
    logic [21:0] load_vpn = '0;
    logic [7:0]  load_asid = '0;
    logic        aw_req = 0;
    logic [21:0] aw_vpn = '0;
    logic [9:0]  aw_data = '0;
    logic        hit, hit_dirty, flush_req;
    logic [5:0]  hit_idx;
    logic [11:0] exc_code;

    always #2 clk = ~clk;

    pgtlb_top dut_i (
        .clk(clk), .rst(rst), .lkp_req(lkp_req), .lkp_vpn(lkp_vpn), .cur_asid(cur_asid),
        .priv_mode(priv_mode), .single_vmode(single_vmode), .load_req(load_req),
        .load_to_itlb(load_to_itlb), .load_islot(load_islot), .load_vpn(load_vpn),
        .load_asid(load_asid), .load_shared(load_shared), .load_valid(load_valid),
        .load_dirty(load_dirty), .aw_req(aw_req), .aw_vpn(aw_vpn), .aw_data(aw_data),
        .hit(hit), .hit_idx(hit_idx), .hit_dirty(hit_dirty), .exc_code(exc_code),
        .flush_req(flush_req));

    // reference model state
    int m_vpn [NU], m_asid [NU], m_sh [NU], m_v [NU], m_d [NU];
    int i_vpn [NI], i_asid [NI], i_sh [NI], i_v [NI];
    int m_ctr = 0;
    int exp_exc = 0, exp_flush = 0;
    int n_chk = 0, n_fail = 0;
    string cur_tag = "R1";

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h at %0t", cur_tag, what, act, exp, $time);
        end
    endtask

    // one clock: compare outputs, advance the model, pass the edge
    task automatic cyc();
        int ck, eh, ei, ed, cnt, slot, nv, nd, aa, nexc, nfl;
        #1;
        ck = !(priv_mode && single_vmode);
        eh = 0; ei = 0; ed = 0;
        if (lkp_req)
            for (int i = 0; i < NU; i++)
                if (m_v[i] != 0 && m_vpn[i] == int'(lkp_vpn) &&
                    (ck == 0 || m_sh[i] != 0 || m_asid[i] == int'(cur_asid))) begin
                    eh = 1; ei = i; ed = m_d[i];
                    break;
                end
        chk("hit", int'(hit), eh);
        chk("hit_idx", int'(hit_idx), ei);
        chk("hit_dirty", int'(hit_dirty), ed);
        chk("exc_code", int'(exc_code), exp_exc);
        chk("flush_req", int'(flush_req), exp_flush);
        nexc = 0; nfl = 0;
        if (aw_req) begin
            nd = int'(aw_data[9]); nv = int'(aw_data[8]); aa = int'(aw_data[7:0]);
            cnt = 0; slot = 0;
            for (int i = 0; i < NU; i++)
                if (m_v[i] != 0 && m_vpn[i] == int'(aw_vpn) &&
                    (ck == 0 || m_sh[i] != 0 || m_asid[i] == aa)) begin
                    if (cnt == 0) slot = i;
                    cnt++;
                end
            if (cnt == 1) begin m_d[slot] = nd; m_v[slot] = nv; end
            if (cnt > 1) nexc = 'h140;
            for (int i = 0; i < NI; i++)
                if (i_vpn[i] == int'(aw_vpn) && (ck == 0 || i_sh[i] != 0 || i_asid[i] == aa)) begin
                    if (i_v[i] != 0 && nv == 0) nfl = 1;
                    i_v[i] = nv;
                end
        end
        if (load_req) begin
            if (load_to_itlb) begin
                i_vpn[load_islot] = int'(load_vpn); i_asid[load_islot] = int'(load_asid);
                i_sh[load_islot] = int'(load_shared); i_v[load_islot] = int'(load_valid);
            end else begin
                m_vpn[m_ctr] = int'(load_vpn); m_asid[m_ctr] = int'(load_asid);
                m_sh[m_ctr] = int'(load_shared); m_v[m_ctr] = int'(load_valid);
                m_d[m_ctr] = int'(load_dirty);
            end
        end
        if (eh != 0) m_ctr = (m_ctr == NU - 1) ? 0 : m_ctr + 1;
        exp_exc = nexc; exp_flush = nfl;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        lkp_req = 0; load_req = 0; aw_req = 0;
    endtask

    task automatic lookup(input int vpn, input int asid, input bit pm, input bit sv);
        idle();
        lkp_req = 1; lkp_vpn = 22'(vpn); cur_asid = 8'(asid); priv_mode = pm; single_vmode = sv;
        cyc();
        idle();
    endtask

    task automatic load_u(input int vpn, input int asid, input bit sh, input bit v, input bit d);
        idle();
        load_req = 1; load_to_itlb = 0; load_vpn = 22'(vpn); load_asid = 8'(asid);
        load_shared = sh; load_valid = v; load_dirty = d;
        cyc();
        idle();
    endtask

    task automatic load_i(input int slot, input int vpn, input int asid, input bit sh, input bit v);
        idle();
        load_req = 1; load_to_itlb = 1; load_islot = 2'(slot); load_vpn = 22'(vpn);
        load_asid = 8'(asid); load_shared = sh; load_valid = v; load_dirty = 0;
        cyc();
        idle();
    endtask

    task automatic awrite(input int vpn, input bit d, input bit v, input int asid,
                          input bit pm, input bit sv);
        idle();
        aw_req = 1; aw_vpn = 22'(vpn); aw_data = {d, v, 8'(asid)};
        priv_mode = pm; single_vmode = sv;
        cyc();
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < NU; i++) begin m_vpn[i] = 0; m_asid[i] = 0; m_sh[i] = 0; m_v[i] = 0; m_d[i] = 0; end
        for (int i = 0; i < NI; i++) begin i_vpn[i] = 0; i_asid[i] = 0; i_sh[i] = 0; i_v[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        cur_tag = "R1";                         // empty table after reset
        cyc();
        lookup(0, 0, 0, 0);

        cur_tag = "R6";                         // first load goes to slot 0
        load_u('h100, 5, 0, 1, 0);
        cur_tag = "R2";
        lookup('h100, 5, 0, 0);
        lookup('h100, 6, 0, 0);                 // identifier mismatch
        lookup('h101, 5, 0, 0);                 // page mismatch

        cur_tag = "R3";                         // shared entry in slot 1
        load_u('h200, 9, 1, 1, 0);
        lookup('h200, 3, 0, 0);

        cur_tag = "R4";
        load_u('h300, 7, 0, 1, 0);
        lookup('h300, 1, 1, 1);                 // checking off
        lookup('h300, 1, 1, 0);                 // checking on
        lookup('h300, 1, 0, 1);                 // checking on

        cur_tag = "R6";                         // two loads land in the same slot
        load_u('h400, 1, 0, 1, 0);
        load_u('h500, 1, 0, 1, 0);
        lookup('h400, 1, 0, 0);
        lookup('h500, 1, 0, 0);

        cur_tag = "R5";                         // duplicate page: lowest slot wins
        load_u('h600, 1, 0, 1, 0);
        lookup('h600, 1, 0, 0);
        load_u('h600, 1, 0, 1, 1);
        lookup('h600, 1, 0, 0);
        cyc();

        cur_tag = "R8";
        awrite('h100, 1, 1, 5, 0, 0);           // single match, set dirty
        lookup('h100, 5, 0, 0);
        awrite('h100, 0, 0, 6, 0, 0);           // identifier mismatch: no change
        lookup('h100, 5, 0, 0);
        awrite('h100, 0, 0, 5, 0, 0);           // clear valid
        lookup('h100, 5, 0, 0);

        cur_tag = "R9";                         // two entries, same page
        load_u('h700, 2, 0, 1, 0);
        lookup('h700, 2, 0, 0);
        load_u('h700, 3, 0, 1, 0);
        awrite('h700, 1, 0, 2, 1, 1);           // both match with checking off
        lookup('h700, 2, 0, 0);
        lookup('h700, 3, 0, 0);
        awrite('h700, 1, 1, 3, 0, 0);           // only one matches with checking on
        lookup('h700, 3, 0, 0);

        cur_tag = "R10";
        load_i(2, 'h800, 4, 0, 1);
        awrite('h800, 0, 0, 9, 0, 0);           // identifier mismatch: no flush
        awrite('h800, 0, 0, 4, 0, 0);           // valid to invalid: flush
        awrite('h800, 0, 0, 4, 0, 0);           // already invalid: no flush
        awrite('h800, 0, 1, 4, 0, 0);           // revalidate
        awrite('h800, 0, 0, 4, 0, 0);           // flush again
        load_i(1, 'h810, 6, 1, 1);
        awrite('h810, 0, 0, 0, 0, 0);           // shared instruction entry
        cyc();

        cur_tag = "R7";                         // wrap the replacement pointer
        for (int k = 0; k < 70; k++) lookup('h200, k, 0, 0);
        load_u('h900, 8, 0, 1, 1);
        lookup('h900, 8, 0, 0);
        for (int k = 0; k < 40; k++) lookup((k % 3 == 0) ? 'h200 : 'h900, 8, 0, 0);
        cyc();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule